// File: doc/BRIEF.md
# SD Command Issuer and Response Capture

This block drives the command line of an SD or MMC card. Software loads a 32-bit argument, then writes a 16-bit command word. That write starts a 48-bit command frame, sent one bit per card clock step, most significant bit first. The response type field of the same word selects what follows: nothing, a 48-bit short response, or a 136-bit long response. A 48-bit response may also be followed by a busy phase on data line 0. The captured payload appears on a 120-bit response output. A one-cycle pulse marks response end or command timeout. A CRC flag accompanies response end when a checked response arrives damaged.

A separate stop register sends the stop-transmission command (index 12, argument zero) without using the command word. The same register also arms an automatic stop. Once armed, the block issues that stop command by itself when the data path reports the end of a multi-block transfer. The card clock is represented by a one-cycle step enable, `sd_tick`. All command-line sampling and driving advance only on that enable.

Top module: `sdc_cmd_issuer`

## Requirements
- R1: After reset, `cmd_out` is 1, `cmd_oe` is 0, `busy` is 0, `resp` is all zeros, and `resp_end`, `cmd_timeout` and `crc_err` are 0.
- R2: An accepted command word sends one frame of 48 bits, most significant bit first, one bit per `sd_tick`, with `cmd_oe` high throughout. The frame is: 0, 1, the index from word bits [5:0], the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, zero seed) of the preceding 40 bits, and a final 1.
- R3: The frame carries the argument register as it stood before the cycle of the command-word write. An argument write in that same cycle applies only to later commands.
- R4: Word bits [10:8] select the response: 3 none, 4 short with CRC check, 5 short with CRC check and busy, 6 long, 7 short without CRC check. Codes 0, 1 and 2 cause the write to be ignored: no frame is sent and `busy` stays 0.
- R5: With response code 3, `resp_end` pulses for one cycle right after the end bit, and `busy` then returns to 0.
- R6: For a 48-bit response, `resp[31:0]` takes the 32 bits that follow the start bit, the transmission bit and the 6 index bits, and `resp[119:32]` becomes 0. `resp` changes only in a cycle where `resp_end` is 1.
- R7: For a 136-bit response, `resp[119:0]` takes the 120 bits that follow the first 8 bits of the response. The last 8 bits (CRC and end bit) are dropped.
- R8: For codes 4 and 5, `crc_err` is 1 together with `resp_end` when the received 7 CRC bits differ from the CRC7 of the first 40 response bits. For codes 6 and 7 it stays 0. `crc_err` is never 1 without `resp_end`.
- R9: If no start bit (0) is seen on `cmd_in` within 64 `sd_tick`s after the end bit, `cmd_timeout` pulses once, `resp_end` does not, `resp` keeps its value, and `busy` falls.
- R10: With code 5, `busy` stays 1 after the response while `dat0_in` reads 0 at each `sd_tick`. It clears after the first `sd_tick` on which `dat0_in` is 1.
- R11: A stop-register write with bit 0 set sends index 12 with argument 0, handled as code 5. A command-word write in the same cycle is dropped.
- R12: Every stop-register write loads bit 8 as the automatic-stop enable. While that enable is set, an `xfer_done` pulse in idle sends index 12 with argument 0, but only if the last command word had bit 13 set. With the enable clear, or after a word without bit 13, `xfer_done` is ignored.
- R13: Command-word, stop-send and `xfer_done` requests arriving while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_tick | input | 1 | One-cycle card clock step enable |
| cmd_wr | input | 1 | Command-word write strobe |
| cmd_word | input | 16 | Command word: index, response code, multi-block flag |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| stop_wr | input | 1 | Stop-register write strobe |
| stop_wdata | input | 16 | Stop value: bit 0 send stop, bit 8 automatic stop enable |
| xfer_done | input | 1 | Multi-block data transfer finished pulse |
| cmd_in | input | 1 | Command line input from card |
| dat0_in | input | 1 | Data line 0 input, low while card is busy |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Command sequence in progress |
| resp | output | 120 | Captured response payload |
| resp_end | output | 1 | Response end pulse |
| cmd_timeout | output | 1 | Command timeout pulse |
| crc_err | output | 1 | Response CRC mismatch, valid with resp_end |

## Verification
Two cycles collide by design. In the first, a stop-send and a command-word write land on the same clock. The bench raises both strobes on one edge and decodes the frame that leaves the line; it must be index 12 with argument zero, and exactly one frame may appear. In the second, an argument write and a command-word write share an edge. The bench decodes the argument field of that frame and of the next one, and expects the old value first and the new value second.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;

    localparam int CMD_FRAME_W = 48;
    localparam int LONG_RSP_W  = 136;
    localparam int RESP_W      = 120;
    localparam int IDX_W       = 6;
    localparam int ARG_W       = 32;
    localparam int WORD_W      = 16;
    localparam logic [IDX_W-1:0] STOP_IDX = 6'd12;

    // response code field values
    localparam logic [2:0] RC_NONE  = 3'd3;
    localparam logic [2:0] RC_SHORT = 3'd4;
    localparam logic [2:0] RC_BUSY  = 3'd5;
    localparam logic [2:0] RC_LONG  = 3'd6;
    localparam logic [2:0] RC_NOCRC = 3'd7;

    typedef enum logic [1:0] {
        C_IDLE,
        C_SEND,
        C_RESP,
        C_BUSY
    } ctl_state_e;

    // bit-serial CRC7, polynomial x^7 + x^3 + 1, zero seed, MSB first
    function automatic logic [6:0] crc7_40(input logic [39:0] d);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb   = d[i] ^ c[6];
            c    = {c[5:0], fb};
            c[3] = c[3] ^ fb;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdc_cmd_ser.sv
module sdc_cmd_ser #(
    parameter int FW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [FW-1:0] frame,
    output logic          line,
    output logic          oe,
    output logic          done
);
    localparam int CW = $clog2(FW);

    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          act;
        logic          done;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load) begin
            d.sh  = frame;
            d.cnt = CW'(FW - 1);
            d.act = 1'b1;
        end else if (q.act && tick) begin
            if (q.cnt == '0) begin
                d.act  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.sh  = {q.sh[FW-2:0], 1'b1};
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sh: '1, cnt: '0, act: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign line = q.act ? q.sh[FW-1] : 1'b1;
    assign oe   = q.act;
    assign done = q.done;

endmodule

// File: rtl/sdc_resp_des.sv
module sdc_resp_des #(
    parameter int FW       = 48,
    parameter int LW       = 136,
    parameter int TO_TICKS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          long_rsp,
    input  logic          cmd_in,
    output logic [LW-2:0] data,
    output logic          got,
    output logic          tout
);
    localparam int SW = LW - 1;
    localparam int CW = $clog2(LW);
    localparam int TW = $clog2(TO_TICKS + 1);

    typedef enum logic [1:0] {
        D_IDLE,
        D_WAIT,
        D_RX
    } des_state_e;

    typedef struct packed {
        des_state_e    st;
        logic [SW-1:0] sh;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tmr;
        logic          got;
        logic          tout;
    } des_t;

    des_t q, d;

    always_comb begin
        d      = q;
        d.got  = 1'b0;
        d.tout = 1'b0;
        case (q.st)
            D_IDLE: begin
                if (start) begin
                    d.st  = D_WAIT;
                    d.tmr = '0;
                end
            end
            D_WAIT: begin
                if (tick) begin
                    if (!cmd_in) begin
                        d.st  = D_RX;
                        d.cnt = long_rsp ? CW'(LW - 2) : CW'(FW - 2);
                    end else if (q.tmr == TW'(TO_TICKS - 1)) begin
                        d.st   = D_IDLE;
                        d.tout = 1'b1;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end
            end
            D_RX: begin
                if (tick) begin
                    d.sh = {q.sh[SW-2:0], cmd_in};
                    if (q.cnt == '0) begin
                        d.st  = D_IDLE;
                        d.got = 1'b1;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            default: d.st = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: D_IDLE, sh: '0, cnt: '0, tmr: '0, got: 1'b0, tout: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data = q.sh;
    assign got  = q.got;
    assign tout = q.tout;

endmodule

// File: rtl/sdc_cmd_issuer.sv
module sdc_cmd_issuer
    import sdc_cmd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64,
    parameter int STOP_BIT      = 0,
    parameter int AUTO_BIT      = 8,
    parameter int MULTI_BIT     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_tick,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              arg_wr,
    input  logic [ARG_W-1:0]  arg_wdata,
    input  logic              stop_wr,
    input  logic [WORD_W-1:0] stop_wdata,
    input  logic              xfer_done,
    input  logic              cmd_in,
    input  logic              dat0_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              busy,
    output logic [RESP_W-1:0] resp,
    output logic              resp_end,
    output logic              cmd_timeout,
    output logic              crc_err
);
    localparam int HDR_W = CMD_FRAME_W - 8;

    typedef struct packed {
        ctl_state_e        st;
        logic [ARG_W-1:0]  arg;
        logic [2:0]        rcode;
        logic              auto_en;
        logic              multi;
        logic [RESP_W-1:0] resp;
        logic              rend;
        logic              tout;
        logic              cerr;
    } ctl_t;

    ctl_t q, d;

    logic                   ser_load;
    logic [CMD_FRAME_W-1:0] ser_frame;
    logic                   ser_done;
    logic                   des_start;
    logic [LONG_RSP_W-2:0]  des_data;
    logic                   des_got;
    logic                   des_tout;

    logic [IDX_W-1:0] tx_idx;
    logic [ARG_W-1:0] tx_arg;
    logic [HDR_W-1:0] tx_hdr;
    logic             stop_req;
    logic             auto_req;
    logic             word_ok;
    logic [2:0]       word_code;

    assign word_code = cmd_word[10:8];
    assign stop_req  = stop_wr && stop_wdata[STOP_BIT];
    assign auto_req  = xfer_done && q.auto_en && q.multi;
    assign word_ok   = cmd_wr && (word_code >= RC_NONE);
    assign tx_hdr    = {2'b01, tx_idx, tx_arg};
    assign ser_frame = {tx_hdr, crc7_40(tx_hdr), 1'b1};

    always_comb begin
        d         = q;
        d.rend    = 1'b0;
        d.tout    = 1'b0;
        d.cerr    = 1'b0;
        ser_load  = 1'b0;
        des_start = 1'b0;
        tx_idx    = STOP_IDX;
        tx_arg    = '0;

        if (arg_wr) begin
            d.arg = arg_wdata;
        end
        if (stop_wr) begin
            d.auto_en = stop_wdata[AUTO_BIT];
        end

        case (q.st)
            C_IDLE: begin
                if (stop_req || auto_req) begin
                    ser_load = 1'b1;
                    d.rcode  = RC_BUSY;
                    d.multi  = 1'b0;
                    d.st     = C_SEND;
                end else if (word_ok) begin
                    ser_load = 1'b1;
                    tx_idx   = cmd_word[IDX_W-1:0];
                    tx_arg   = q.arg;
                    d.rcode  = word_code;
                    d.multi  = cmd_word[MULTI_BIT];
                    d.st     = C_SEND;
                end
            end
            C_SEND: begin
                if (ser_done) begin
                    if (q.rcode == RC_NONE) begin
                        d.rend = 1'b1;
                        d.st   = C_IDLE;
                    end else begin
                        des_start = 1'b1;
                        d.st      = C_RESP;
                    end
                end
            end
            C_RESP: begin
                if (des_got) begin
                    if (q.rcode == RC_LONG) begin
                        d.resp = des_data[RESP_W+7:8];
                    end else begin
                        d.resp = {{(RESP_W-ARG_W){1'b0}}, des_data[ARG_W+7:8]};
                    end
                    if ((q.rcode == RC_SHORT) || (q.rcode == RC_BUSY)) begin
                        d.cerr = crc7_40({1'b0, des_data[HDR_W+6:8]}) != des_data[7:1];
                    end
                    d.rend = 1'b1;
                    d.st   = (q.rcode == RC_BUSY) ? C_BUSY : C_IDLE;
                end else if (des_tout) begin
                    d.tout = 1'b1;
                    d.st   = C_IDLE;
                end
            end
            C_BUSY: begin
                if (sd_tick && dat0_in) begin
                    d.st = C_IDLE;
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: C_IDLE, arg: '0, rcode: RC_NONE, auto_en: 1'b0, multi: 1'b0,
                   resp: '0, rend: 1'b0, tout: 1'b0, cerr: 1'b0};
        end else begin
            q <= d;
        end
    end

    sdc_cmd_ser #(
        .FW (CMD_FRAME_W)
    ) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sd_tick),
        .load  (ser_load),
        .frame (ser_frame),
        .line  (cmd_out),
        .oe    (cmd_oe),
        .done  (ser_done)
    );

    sdc_resp_des #(
        .FW       (CMD_FRAME_W),
        .LW       (LONG_RSP_W),
        .TO_TICKS (TIMEOUT_TICKS)
    ) u_des (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sd_tick),
        .start    (des_start),
        .long_rsp (q.rcode == RC_LONG),
        .cmd_in   (cmd_in),
        .data     (des_data),
        .got      (des_got),
        .tout     (des_tout)
    );

    assign busy        = (q.st != C_IDLE);
    assign resp        = q.resp;
    assign resp_end    = q.rend;
    assign cmd_timeout = q.tout;
    assign crc_err     = q.cerr;

endmodule

// File: rtl/sdc_cmd_issuer_chk.sv
module sdc_cmd_issuer_chk
    import sdc_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_oe,
    input logic              cmd_out,
    input logic              busy,
    input logic [RESP_W-1:0] resp,
    input logic              resp_end,
    input logic              cmd_timeout,
    input logic              crc_err
);

    assert_end_tout_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_end && cmd_timeout));

    assert_crc_with_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> resp_end);

    assert_drive_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy);

    assert_start_from_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> $past(!busy));

    assert_timeout_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_timeout |-> !busy);

    assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_end |-> $stable(resp));

    assert_no_drive_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_end |-> !cmd_oe);

endmodule

bind sdc_cmd_issuer sdc_cmd_issuer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_oe      (cmd_oe),
    .cmd_out     (cmd_out),
    .busy        (busy),
    .resp        (resp),
    .resp_end    (resp_end),
    .cmd_timeout (cmd_timeout),
    .crc_err     (crc_err)
);

// File: tb/sdc_cmd_issuer_bench.sv
`timescale 1ns/1ps
module sdc_cmd_issuer_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sd_tick = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_word = '0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic         stop_wr = 1'b0;
    logic [15:0]  stop_wdata = '0;
    logic         xfer_done = 1'b0;
    logic         cmd_in = 1'b1;
    logic         dat0_in = 1'b1;
    logic         cmd_out;
    logic         cmd_oe;
    logic         busy;
    logic [119:0] resp;
    logic         resp_end;
    logic         cmd_timeout;
    logic         crc_err;

    int n_chk = 0;
    int n_fail = 0;
    int n_frames = 0;
    int n_end = 0;
    int n_to = 0;
    int n_ticks = 0;
    bit last_crc = 1'b0;
    bit oe_prev = 1'b0;
    bit finished = 1'b0;
    logic [1:0] tdiv = '0;

    always #2 clk = ~clk;

    sdc_cmd_issuer u_sdc_cmd_issuer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sd_tick     (sd_tick),
        .cmd_wr      (cmd_wr),
        .cmd_word    (cmd_word),
        .arg_wr      (arg_wr),
        .arg_wdata   (arg_wdata),
        .stop_wr     (stop_wr),
        .stop_wdata  (stop_wdata),
        .xfer_done   (xfer_done),
        .cmd_in      (cmd_in),
        .dat0_in     (dat0_in),
        .cmd_out     (cmd_out),
        .cmd_oe      (cmd_oe),
        .busy        (busy),
        .resp        (resp),
        .resp_end    (resp_end),
        .cmd_timeout (cmd_timeout),
        .crc_err     (crc_err)
    );

    // card clock step: one cycle in four
    always @(posedge clk) begin
        tdiv    <= tdiv + 2'd1;
        sd_tick <= (tdiv == 2'd2);
    end

    // event monitor, just after each edge
    always @(posedge clk) begin
        #1;
        if (cmd_oe && !oe_prev) n_frames++;
        oe_prev = cmd_oe;
        if (resp_end) begin
            n_end++;
            last_crc = crc_err;
        end
        if (cmd_timeout) n_to++;
        if (sd_tick) n_ticks++;
    end

    function automatic logic [6:0] ref_crc(input logic [39:0] v);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic b;
            b = v[i] ^ r[6];
            r = {r[5:0], 1'b0};
            if (b) r = r ^ 7'h09;
        end
        return r;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] a);
        logic [39:0] h;
        h = {2'b01, idx, a};
        return {h, ref_crc(h), 1'b1};
    endfunction

    function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] s, input bit bad);
        logic [39:0] h;
        h = {2'b00, idx, s};
        return {h, ref_crc(h) ^ {6'd0, bad}, 1'b1};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic at_tick();
        while (!sd_tick) @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wr_arg(input logic [31:0] a);
        @(negedge clk);
        arg_wr = 1'b1; arg_wdata = a;
        @(negedge clk);
        arg_wr = 1'b0;
    endtask

    task automatic wr_stop(input logic [15:0] v);
        @(negedge clk);
        stop_wr = 1'b1; stop_wdata = v;
        @(negedge clk);
        stop_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic grab(output logic [47:0] f);
        int g = 0;
        f = '0;
        while (!cmd_oe && g < 40) begin
            @(negedge clk);
            g++;
        end
        if (!cmd_oe) return;
        for (int i = 47; i >= 0; i--) begin
            at_tick();
            f[i] = cmd_out;
            @(negedge clk);
        end
    endtask

    task automatic respond(input logic [135:0] bits, input int n);
        cmd_in = 1'b1;
        at_tick();
        @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            at_tick();
            cmd_in = bits[i];
            @(negedge clk);
        end
        at_tick();
        cmd_in = 1'b1;
        @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic settle(input int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        logic [47:0]  f;
        logic [119:0] pay;
        logic [119:0] keep;
        int fr0, en0, to0, t0, g;

        repeat (3) @(negedge clk);
        check(cmd_out === 1'b1 && cmd_oe === 1'b0 && busy === 1'b0, "R1 line/busy at reset",
              {cmd_out, cmd_oe, busy}, 3'b100);
        check(resp === '0 && resp_end === 1'b0 && cmd_timeout === 1'b0 && crc_err === 1'b0,
              "R1 response at reset", resp, 0);
        rst_n = 1'b1;
        settle(2);

        // R2 / R5: every index, no response
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = (32'h01010101 * i) ^ 32'hA5C3_0F96;
            en0 = n_end;
            wr_arg(a);
            wr_cmd(16'h0300 | 16'(i));
            grab(f);
            check(f === exp_frame(6'(i), a), "R2 frame sweep", f, exp_frame(6'(i), a));
            settle(4);
            if (i % 16 == 0)
                check(n_end == en0 + 1 && busy === 1'b0, "R5 end after frame",
                      n_end - en0, 1);
        end

        // R3: argument write in the command cycle
        wr_arg(32'h1111_2222);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = 16'h0307; arg_wr = 1'b1; arg_wdata = 32'h3333_4444;
        @(negedge clk);
        cmd_wr = 1'b0; arg_wr = 1'b0;
        grab(f);
        check(f === exp_frame(6'd7, 32'h1111_2222), "R3 old arg used", f, exp_frame(6'd7, 32'h1111_2222));
        settle(4);
        wr_cmd(16'h0308);
        grab(f);
        check(f === exp_frame(6'd8, 32'h3333_4444), "R3 new arg later", f, exp_frame(6'd8, 32'h3333_4444));
        settle(4);

        // R4: codes 0..2 ignored
        for (int t = 0; t < 3; t++) begin
            fr0 = n_frames;
            wr_cmd(16'(t << 8) | 16'h0009);
            settle(30);
            check(n_frames == fr0 && busy === 1'b0, "R4 invalid code ignored", n_frames - fr0, 0);
        end

        // R6: short response with CRC
        wr_arg(32'h0000_0120);
        en0 = n_end;
        wr_cmd(16'h0411);
        grab(f);
        respond({88'd0, short_rsp(6'h11, 32'hDEAD_BEEF, 1'b0)}, 48);
        check(n_end == en0 + 1 && resp === {88'd0, 32'hDEAD_BEEF}, "R6 short capture", resp, 32'hDEAD_BEEF);
        check(last_crc == 1'b0 && busy === 1'b0, "R8 good CRC clean", last_crc, 0);

        // R8: damaged CRC on checked code
        wr_cmd(16'h0412);
        grab(f);
        respond({88'd0, short_rsp(6'h12, 32'h0BAD_F00D, 1'b1)}, 48);
        check(last_crc == 1'b1, "R8 CRC mismatch flagged", last_crc, 1);
        check(resp === {88'd0, 32'h0BAD_F00D}, "R6 short capture on error", resp, 32'h0BAD_F00D);

        // R8: unchecked code
        wr_cmd(16'h0713);
        grab(f);
        respond({88'd0, 2'b00, 6'h3F, 32'h80FF_8000, 8'h01}, 48);
        check(last_crc == 1'b0 && resp === {88'd0, 32'h80FF_8000}, "R8 no check on code 7", last_crc, 0);

        // R7: long response
        pay = '0;
        for (int k = 0; k < 15; k++) pay[k*8 +: 8] = 8'(k * 17 + 3);
        wr_cmd(16'h0602);
        grab(f);
        respond({2'b00, 6'h3F, pay, 7'h55, 1'b1}, 136);
        check(resp === pay, "R7 long payload", resp, pay);
        check(last_crc == 1'b0 && busy === 1'b0, "R8 no check on long", last_crc, 0);

        // R9: timeout
        keep = resp;
        to0 = n_to; en0 = n_end;
        wr_cmd(16'h0408);
        grab(f);
        t0 = n_ticks + 1;
        g = 0;
        while (n_to == to0 && g < 600) begin
            @(negedge clk);
            g++;
        end
        check(n_to == to0 + 1 && (n_ticks - t0) >= 63 && (n_ticks - t0) <= 65, "R9 timeout window",
              n_ticks - t0, 64);
        check(n_end == en0 && resp === keep && busy === 1'b0, "R9 resp kept", resp, keep);

        // R13: second write while busy dropped
        fr0 = n_frames;
        wr_cmd(16'h0301);
        settle(20);
        wr_cmd(16'h0302);
        settle(300);
        check(n_frames == fr0 + 1 && busy === 1'b0, "R13 write while busy ignored", n_frames - fr0, 1);

        // R11 + R10: stop send, busy on data line 0
        dat0_in = 1'b0;
        wr_stop(16'h0001);
        grab(f);
        check(f === exp_frame(6'd12, 32'd0), "R11 stop frame", f, exp_frame(6'd12, 32'd0));
        respond({88'd0, short_rsp(6'd12, 32'h0000_0900, 1'b0)}, 48);
        check(busy === 1'b1, "R10 busy held by dat0", busy, 1);
        repeat (5) begin at_tick(); @(negedge clk); end
        check(busy === 1'b1, "R10 busy still held", busy, 1);
        dat0_in = 1'b1;
        settle(10);
        check(busy === 1'b0, "R10 busy released", busy, 0);

        // R11: stop and command in the same cycle
        fr0 = n_frames;
        @(negedge clk);
        stop_wr = 1'b1; stop_wdata = 16'h0001; cmd_wr = 1'b1; cmd_word = 16'h0305;
        @(negedge clk);
        stop_wr = 1'b0; cmd_wr = 1'b0;
        grab(f);
        check(f === exp_frame(6'd12, 32'd0), "R11 stop wins same cycle", f, exp_frame(6'd12, 32'd0));
        respond({88'd0, short_rsp(6'd12, 32'h0, 1'b0)}, 48);
        settle(20);
        check(n_frames == fr0 + 1, "R11 command dropped", n_frames - fr0, 1);

        // R12: automatic stop
        wr_stop(16'h0100);
        wr_cmd(16'h2312);
        grab(f);
        settle(6);
        pulse_done();
        grab(f);
        check(f === exp_frame(6'd12, 32'd0), "R12 auto stop frame", f, exp_frame(6'd12, 32'd0));
        respond({88'd0, short_rsp(6'd12, 32'h0, 1'b0)}, 48);
        settle(10);
        wr_cmd(16'h0314);
        grab(f);
        settle(6);
        fr0 = n_frames;
        pulse_done();
        settle(40);
        check(n_frames == fr0, "R12 single-block no auto stop", n_frames - fr0, 0);
        wr_stop(16'h0000);
        wr_cmd(16'h2315);
        grab(f);
        settle(6);
        fr0 = n_frames;
        pulse_done();
        settle(40);
        check(n_frames == fr0 && busy === 1'b0, "R12 disabled auto stop", n_frames - fr0, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule